// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherency Controller

This block keeps the coherency state of the secondary-cache lines owned by one processor node. The node shares a split-read, snooping system bus with up to three other caching agents. It holds a small direct-mapped array of tags and line states. Each line is invalid, shared, clean exclusive or dirty exclusive. There is no dirty-shared state. Local read and write requests carry a page attribute that marks them sharable or noncoherent. A noncoherent access skips the protocol entirely.

For a sharable request, the controller looks up the line. It completes hits at once and changes a clean exclusive line to dirty exclusive without any bus traffic. When bus traffic is needed, it requests the bus and waits for the grant. It then issues one of four transaction types: read, read exclusive, write (a dirty victim writeback) or invalidate. A read or read exclusive is split, so the controller keeps a pending record until the fill response arrives. It watches every transaction from the other agents on its snoop input and downgrades or drops matching lines. For each snoop it reports whether it holds the line and whether it must supply dirty data. An invalidation that strikes a pending read is remembered, so the fill lands as invalid. An invalidation that strikes a pending upgrade turns that upgrade into a read exclusive.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, breq, bus_valid, done_valid, snp_hit and snp_supply are 0. All lines start invalid, so the first sharable access to any address is a miss. lreq_ready is 1 when the controller is idle and no snoop is present.
- R2: A sharable read miss raises breq. One cycle after a grant it drives bus_valid with bus_op read (0) and the line address. The cycle after fill_valid, it reports done_valid with done_state clean exclusive (2) if fill_shared was 0, or shared (1) if fill_shared was 1. The line is left in that state.
- R3: A sharable write miss issues a read exclusive (bus_op 1) and completes, the cycle after its fill, as dirty exclusive (3).
- R4: A sharable read hit completes in the next cycle with the line's current state, and no bus transaction. A sharable write hit on a clean or dirty exclusive line completes in the next cycle as dirty exclusive, with no bus transaction.
- R5: A sharable write hit on a shared line issues an invalidate (bus_op 3) after the grant. In that same cycle done_valid reports dirty exclusive.
- R6: A coherent snooped read that hits a valid line sets snp_hit in the next cycle and leaves the line shared. snp_supply is also set when the line was dirty exclusive. A snooped read exclusive that hits a dirty exclusive line also sets snp_supply.
- R7: A coherent snooped read exclusive or invalidate that hits a valid line sets snp_hit in the next cycle and makes the line invalid. Snooped writes and snoops that miss change nothing.
- R8: A noncoherent local request completes in the next cycle with done_state invalid (0). It issues no bus transaction and changes no line. A noncoherent snoop gives snp_hit = snp_supply = 0 and changes no line.
- R9: If a coherent invalidate or read exclusive to the pending address is snooped while a read or read exclusive waits for its fill, the fill completes with done_state invalid, and the line stays invalid.
- R10: If an upgrade is waiting for its grant and the shared line is snooped away by an invalidate or read exclusive, the controller issues a read exclusive instead of an invalidate. It then completes as dirty exclusive after the fill.
- R11: A miss whose victim line at the same index is dirty exclusive first issues a write (bus_op 2) to the victim's address. It then issues the miss transaction, which needs a second grant. The victim is then invalid.
- R12: bus_valid is set only in the cycle after breq and bgnt were both high with no snoop present. Once raised, breq stays high until such a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request present |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_coh | input | 1 | 1 = sharable page, 0 = noncoherent |
| lreq_addr | input | ADDR_W | Local line address (low IDX_W bits index the array) |
| lreq_ready | output | 1 | Request is accepted in this cycle if lreq_valid is high |
| done_valid | output | 1 | Local request completed |
| done_state | output | 2 | Resulting line state: 0 invalid, 1 shared, 2 clean excl., 3 dirty excl. |
| breq | output | 1 | Bus request |
| bgnt | input | 1 | Bus grant from the global arbiter |
| bus_valid | output | 1 | Bus transaction issued this cycle |
| bus_op | output | 2 | 0 read, 1 read exclusive, 2 write, 3 invalidate |
| bus_addr | output | ADDR_W | Transaction line address |
| fill_valid | input | 1 | Data response for the pending read |
| fill_shared | input | 1 | Another agent reported a shared hit for that read |
| snp_valid | input | 1 | Transaction by another agent observed on the bus |
| snp_op | input | 2 | Snooped transaction type, same encoding as bus_op |
| snp_coh | input | 1 | Snooped access is sharable |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_hit | output | 1 | Snooped line was held valid (registered) |
| snp_supply | output | 1 | Snooped line was dirty and must be supplied (registered) |

## Verification
On every cycle, the assertions check the bus discipline: no transaction without a prior grant, and a held request. They also check that a supply indication always comes with a hit, and that noncoherent snoops get no response. An issued invalidate must coincide with a dirty exclusive completion, and the outputs must be quiet after reset. The line state changes can be shown only by the bench's scenarios, which watch later hits, snoop responses and bus traffic. These cover the silent upgrade, the downgrade of a clean line to shared, the fill that an invalidate kills, the upgrade that turns into a read exclusive, and the victim writeback before a miss.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_CEX = 2'd2,
    LS_DEX = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_RD  = 2'd0,
    BOP_RDX = 2'd1,
    BOP_WR  = 2'd2,
    BOP_INV = 2'd3
  } bus_op_t;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_ARB  = 2'd1,
    CT_WAIT = 2'd2
  } ctl_st_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output logic [1:0]       a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output logic [1:0]       b_st,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic [TAG_W-1:0] wa_tag,
  input  logic [1:0]       wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [1:0]       wb_st
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [1:0]       st_mem  [DEPTH];

  assign a_tag = tag_mem[a_idx];
  assign a_st  = st_mem[a_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_st  = st_mem[b_idx];

  always_ff @(posedge clk) begin
    if (wa_en) tag_mem[wa_idx] <= wa_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_mem[i] <= coh_pkg::LS_INV;
    end else begin
      if (wb_en && !(wa_en && wa_idx == wb_idx)) st_mem[wb_idx] <= wb_st;
      if (wa_en) st_mem[wa_idx] <= wa_st;
    end
  end
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_op,
  input  logic                    snp_coh,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  logic [ADDR_W-IDX_W-1:0] s_tag,
  input  logic [1:0]              s_st,
  input  logic [ADDR_W-1:0]       p_addr,
  output logic                    wb_en,
  output logic [1:0]              wb_st,
  output logic                    addr_kill,
  output logic                    snp_hit,
  output logic                    snp_supply
);
  import coh_pkg::*;

  logic coh_ev, hit, supply, takes_line;

  always_comb begin
    coh_ev     = snp_valid && snp_coh;
    hit        = coh_ev && (s_st != LS_INV) && (s_tag == snp_addr[ADDR_W-1:IDX_W]);
    takes_line = (snp_op == BOP_RDX) || (snp_op == BOP_INV);
    supply     = hit && (s_st == LS_DEX) && ((snp_op == BOP_RD) || (snp_op == BOP_RDX));
    wb_en      = 1'b0;
    wb_st      = LS_INV;
    if (snp_op == BOP_RD) begin
      wb_en = hit && (s_st != LS_SHR);
      wb_st = LS_SHR;
    end else if (takes_line) begin
      wb_en = hit;
      wb_st = LS_INV;
    end
    addr_kill = coh_ev && takes_line && (snp_addr == p_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_hit    <= 1'b0;
      snp_supply <= 1'b0;
    end else begin
      snp_hit    <= hit;
      snp_supply <= supply;
    end
  end
endmodule

// File: rtl/coh_req_ctrl.sv
module coh_req_ctrl #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lreq_valid,
  input  logic                    lreq_write,
  input  logic                    lreq_coh,
  input  logic [ADDR_W-1:0]       lreq_addr,
  input  logic                    snp_busy,
  input  logic                    addr_kill,
  input  logic                    bgnt,
  input  logic                    fill_valid,
  input  logic                    fill_shared,
  input  logic [ADDR_W-IDX_W-1:0] l_tag,
  input  logic [1:0]              l_st,
  output logic [IDX_W-1:0]        look_idx,
  output logic                    lw_en,
  output logic [IDX_W-1:0]        lw_idx,
  output logic [ADDR_W-IDX_W-1:0] lw_tag,
  output logic [1:0]              lw_st,
  output logic                    lreq_ready,
  output logic                    breq,
  output logic                    bus_valid,
  output logic [1:0]              bus_op,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    done_valid,
  output logic [1:0]              done_state,
  output logic [ADDR_W-1:0]       p_addr_o
);
  import coh_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_t           st_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [1:0]        p_op_q, p_next_q;
  logic [TAG_W-1:0]  v_tag_q;
  logic              p_rdx_q, p_kill_q;

  logic             acc, l_hit, grant_ok;
  logic [1:0]       miss_op, fill_st;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx, p_idx;
  logic [TAG_W-1:0] p_tag;

  assign p_addr_o   = p_addr_q;
  assign lreq_ready = (st_q == CT_IDLE) && !snp_busy;

  always_comb begin
    req_tag  = lreq_addr[ADDR_W-1:IDX_W];
    req_idx  = lreq_addr[IDX_W-1:0];
    p_tag    = p_addr_q[ADDR_W-1:IDX_W];
    p_idx    = p_addr_q[IDX_W-1:0];
    look_idx = (st_q == CT_IDLE) ? req_idx : p_idx;
    acc      = lreq_ready && lreq_valid;
    l_hit    = (l_st != LS_INV) && (l_tag == req_tag);
    miss_op  = lreq_write ? BOP_RDX : BOP_RD;
    grant_ok = (st_q == CT_ARB) && bgnt && !snp_busy;
    if (p_kill_q || addr_kill) fill_st = LS_INV;
    else if (p_rdx_q)          fill_st = LS_DEX;
    else if (fill_shared)      fill_st = LS_SHR;
    else                       fill_st = LS_CEX;

    lw_en  = 1'b0;
    lw_idx = p_idx;
    lw_tag = p_tag;
    lw_st  = LS_INV;
    case (st_q)
      CT_IDLE: begin
        if (acc && lreq_coh && lreq_write && l_hit && l_st != LS_SHR) begin
          lw_en  = 1'b1;
          lw_idx = req_idx;
          lw_tag = req_tag;
          lw_st  = LS_DEX;
        end
      end
      CT_ARB: begin
        if (grant_ok && p_op_q == BOP_WR) begin
          lw_en  = 1'b1;
          lw_tag = v_tag_q;
          lw_st  = LS_INV;
        end else if (grant_ok && p_op_q == BOP_INV) begin
          lw_en  = 1'b1;
          lw_st  = LS_DEX;
        end
      end
      CT_WAIT: begin
        if (fill_valid) begin
          lw_en = 1'b1;
          lw_st = fill_st;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CT_IDLE;
      p_addr_q   <= '0;
      p_op_q     <= BOP_RD;
      p_next_q   <= BOP_RD;
      v_tag_q    <= '0;
      p_rdx_q    <= 1'b0;
      p_kill_q   <= 1'b0;
      breq       <= 1'b0;
      bus_valid  <= 1'b0;
      bus_op     <= BOP_RD;
      bus_addr   <= '0;
      done_valid <= 1'b0;
      done_state <= LS_INV;
    end else begin
      bus_valid  <= 1'b0;
      done_valid <= 1'b0;
      case (st_q)
        CT_IDLE: begin
          if (acc) begin
            p_addr_q <= lreq_addr;
            if (!lreq_coh) begin
              done_valid <= 1'b1;
              done_state <= LS_INV;
            end else if (l_hit && !lreq_write) begin
              done_valid <= 1'b1;
              done_state <= l_st;
            end else if (l_hit && l_st != LS_SHR) begin
              done_valid <= 1'b1;
              done_state <= LS_DEX;
            end else begin
              if (l_hit) begin
                p_op_q <= BOP_INV;
              end else if (l_st == LS_DEX) begin
                p_op_q   <= BOP_WR;
                p_next_q <= miss_op;
                v_tag_q  <= l_tag;
              end else begin
                p_op_q <= miss_op;
              end
              st_q <= CT_ARB;
              breq <= 1'b1;
            end
          end
        end
        CT_ARB: begin
          if (addr_kill && p_op_q == BOP_INV) begin
            p_op_q <= BOP_RDX;
          end else if (grant_ok) begin
            bus_valid <= 1'b1;
            bus_op    <= p_op_q;
            bus_addr  <= (p_op_q == BOP_WR) ? {v_tag_q, p_idx} : p_addr_q;
            case (p_op_q)
              BOP_WR: p_op_q <= p_next_q;
              BOP_INV: begin
                breq       <= 1'b0;
                done_valid <= 1'b1;
                done_state <= LS_DEX;
                st_q       <= CT_IDLE;
              end
              default: begin
                breq     <= 1'b0;
                p_rdx_q  <= (p_op_q == BOP_RDX);
                p_kill_q <= 1'b0;
                st_q     <= CT_WAIT;
              end
            endcase
          end
        end
        CT_WAIT: begin
          if (fill_valid) begin
            done_valid <= 1'b1;
            done_state <= fill_st;
            st_q       <= CT_IDLE;
          end else if (addr_kill) begin
            p_kill_q <= 1'b1;
          end
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lreq_valid,
  input  logic              lreq_write,
  input  logic              lreq_coh,
  input  logic [ADDR_W-1:0] lreq_addr,
  output logic              lreq_ready,
  output logic              done_valid,
  output logic [1:0]        done_state,
  output logic              breq,
  input  logic              bgnt,
  output logic              bus_valid,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              fill_valid,
  input  logic              fill_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic              snp_coh,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx, lw_idx;
  logic [TAG_W-1:0]  l_tag, s_tag, lw_tag;
  logic [1:0]        l_st, s_st, lw_st, wb_st;
  logic              lw_en, wb_en, addr_kill;
  logic [ADDR_W-1:0] p_addr;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(look_idx), .a_tag(l_tag), .a_st(l_st),
    .b_idx(snp_addr[IDX_W-1:0]), .b_tag(s_tag), .b_st(s_st),
    .wa_en(lw_en), .wa_idx(lw_idx), .wa_tag(lw_tag), .wa_st(lw_st),
    .wb_en(wb_en), .wb_idx(snp_addr[IDX_W-1:0]), .wb_st(wb_st)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_coh(snp_coh), .snp_addr(snp_addr),
    .s_tag(s_tag), .s_st(s_st), .p_addr(p_addr),
    .wb_en(wb_en), .wb_st(wb_st), .addr_kill(addr_kill),
    .snp_hit(snp_hit), .snp_supply(snp_supply)
  );

  coh_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_coh(lreq_coh),
    .lreq_addr(lreq_addr), .snp_busy(snp_valid), .addr_kill(addr_kill),
    .bgnt(bgnt), .fill_valid(fill_valid), .fill_shared(fill_shared),
    .l_tag(l_tag), .l_st(l_st), .look_idx(look_idx),
    .lw_en(lw_en), .lw_idx(lw_idx), .lw_tag(lw_tag), .lw_st(lw_st),
    .lreq_ready(lreq_ready), .breq(breq),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
    .done_valid(done_valid), .done_state(done_state), .p_addr_o(p_addr)
  );
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       breq,
  input logic       bgnt,
  input logic       snp_valid,
  input logic       snp_coh,
  input logic       bus_valid,
  input logic [1:0] bus_op,
  input logic       done_valid,
  input logic [1:0] done_state,
  input logic       snp_hit,
  input logic       snp_supply
);
  logic rst_q;

  always_ff @(posedge clk) begin
    // R1
    if (rst_q) begin
      reset_idle_chk: assert (!breq && !bus_valid && !done_valid && !snp_hit && !snp_supply);
    end
    rst_q <= rst;
  end

  // R12
  bus_grant_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> $past(breq && bgnt && !snp_valid));

  // R12
  breq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (breq && !(bgnt && !snp_valid)) |=> breq);

  // R6
  supply_hit_chk: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_hit);

  // R8
  nc_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(snp_valid && !snp_coh) |-> (!snp_hit && !snp_supply));

  // R5
  upgrade_done_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_op == 2'd3) |-> (done_valid && done_state == 2'd3));
endmodule

bind snoop_coh_ctrl coh_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .breq(breq), .bgnt(bgnt), .snp_valid(snp_valid),
  .snp_coh(snp_coh), .bus_valid(bus_valid), .bus_op(bus_op),
  .done_valid(done_valid), .done_state(done_state),
  .snp_hit(snp_hit), .snp_supply(snp_supply)
);

// File: tb/snoop_coh_ctrl_tb_top.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_tb_top;
  localparam int AW = 12;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_C = 2'd2, S_D = 2'd3;
  localparam logic [1:0] O_RD = 2'd0, O_RDX = 2'd1, O_WR = 2'd2, O_INV = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lreq_valid = 0, lreq_write = 0, lreq_coh = 0;
  logic [AW-1:0] lreq_addr = '0;
  logic lreq_ready, done_valid, breq, bus_valid, snp_hit, snp_supply;
  logic [1:0] done_state, bus_op;
  logic [AW-1:0] bus_addr;
  logic bgnt = 0, fill_valid = 0, fill_shared = 0;
  logic snp_valid = 0, snp_coh = 0;
  logic [1:0] snp_op = 2'd0;
  logic [AW-1:0] snp_addr = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 0;

  logic [AW+1:0] exp_bus[$];
  string         exp_bus_r[$];
  logic [1:0]    exp_done[$];
  string         exp_done_r[$];

  always #4 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(AW), .IDX_W(4)) dut_i (
    .clk(clk), .rst(rst),
    .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_coh(lreq_coh),
    .lreq_addr(lreq_addr), .lreq_ready(lreq_ready),
    .done_valid(done_valid), .done_state(done_state),
    .breq(breq), .bgnt(bgnt),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
    .fill_valid(fill_valid), .fill_shared(fill_shared),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_coh(snp_coh), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_supply(snp_supply)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bus transactions and completions
  always @(negedge clk) begin
    if (!rst && !fin) begin
      if (bus_valid) begin
        if (exp_bus.size() == 0) chk(0, "unexpected_bus", {bus_op, bus_addr}, 0);
        else begin
          logic [AW+1:0] e;
          string r;
          e = exp_bus.pop_front();
          r = exp_bus_r.pop_front();
          chk({bus_op, bus_addr} == e, r, {bus_op, bus_addr}, e);
        end
      end
      if (done_valid) begin
        if (exp_done.size() == 0) chk(0, "unexpected_done", done_state, 0);
        else begin
          logic [1:0] e;
          string r;
          e = exp_done.pop_front();
          r = exp_done_r.pop_front();
          chk(done_state == e, r, done_state, e);
        end
      end
    end
  end

  task automatic push_bus(input logic [1:0] op, input logic [AW-1:0] a, input string r);
    exp_bus.push_back({op, a});
    exp_bus_r.push_back(r);
  endtask

  task automatic push_done(input logic [1:0] s, input string r);
    exp_done.push_back(s);
    exp_done_r.push_back(r);
  endtask

  task automatic req(input logic [AW-1:0] a, input bit wr, input bit coh);
    @(negedge clk);
    while (!lreq_ready) @(negedge clk);
    lreq_valid = 1; lreq_write = wr; lreq_coh = coh; lreq_addr = a;
    @(negedge clk);
    lreq_valid = 0;
  endtask

  task automatic grant();
    int n = 0;
    while (!breq && n < 50) begin @(negedge clk); n++; end
    bgnt = 1;
    @(negedge clk);
    bgnt = 0;
  endtask

  task automatic fill(input bit sh);
    fill_valid = 1; fill_shared = sh;
    @(negedge clk);
    fill_valid = 0; fill_shared = 0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input bit coh,
                       input bit e_hit, input bit e_sup, input string r);
    snp_valid = 1; snp_op = op; snp_addr = a; snp_coh = coh;
    @(negedge clk);
    snp_valid = 0; snp_coh = 0;
    chk(snp_hit == e_hit && snp_supply == e_sup, r, {snp_hit, snp_supply}, {e_hit, e_sup});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(lreq_ready && !breq && !bus_valid && !done_valid && !snp_hit && !snp_supply,
        "R1 reset outputs", {lreq_ready, breq, bus_valid, done_valid}, 4'b1000);

    // R2 read miss, unshared fill -> clean exclusive (also R1: first access misses)
    push_bus(O_RD, 12'h010, "R2 read miss issues read");
    push_done(S_C, "R2 unshared fill clean exclusive");
    req(12'h010, 0, 1); grant(); fill(0); settle();

    // R4 read hit, no bus
    push_done(S_C, "R4 read hit state");
    req(12'h010, 0, 1); settle();
    // R4 silent write hit on clean exclusive
    push_done(S_D, "R4 write hit silent upgrade");
    req(12'h010, 1, 1); settle();

    // R6 snoop read on dirty -> supply, line shared
    snoop(O_RD, 12'h010, 1, 1, 1, "R6 snoop read dirty supply");
    push_done(S_S, "R6 dirty line now shared");
    req(12'h010, 0, 1); settle();

    // R5 write hit shared -> invalidate
    push_bus(O_INV, 12'h010, "R5 invalidate issued");
    push_done(S_D, "R5 upgrade completes dirty");
    req(12'h010, 1, 1); grant(); settle();

    // R7 snoop read exclusive on dirty: supply, then invalid
    snoop(O_RDX, 12'h010, 1, 1, 1, "R7 snoop rdx hit dirty");
    snoop(O_RD, 12'h010, 1, 0, 0, "R7 line invalid after rdx");

    // R2 shared fill; R7 snoop invalidate
    push_bus(O_RD, 12'h021, "R2 read miss B");
    push_done(S_S, "R2 shared fill");
    req(12'h021, 0, 1); grant(); fill(1); settle();
    snoop(O_WR, 12'h021, 1, 1, 0, "R7 snoop write leaves line");
    snoop(O_INV, 12'h021, 1, 1, 0, "R7 snoop inv hit shared");
    snoop(O_RD, 12'h021, 1, 0, 0, "R7 line invalid after inv");

    // R3 write miss
    push_bus(O_RDX, 12'h032, "R3 write miss issues rdx");
    push_done(S_D, "R3 write miss fills dirty");
    req(12'h032, 1, 1); grant(); fill(0); settle();

    // R11 dirty victim writeback first
    push_bus(O_WR, 12'h032, "R11 victim writeback");
    push_bus(O_RD, 12'h132, "R11 miss after writeback");
    push_done(S_C, "R11 new line clean exclusive");
    req(12'h132, 0, 1); grant(); grant(); fill(0); settle();
    snoop(O_RD, 12'h032, 1, 0, 0, "R11 victim invalid");

    // R8 noncoherent requests bypass
    push_done(S_I, "R8 noncoherent read done invalid");
    req(12'h010, 0, 0); settle();
    push_done(S_I, "R8 noncoherent write done invalid");
    req(12'h132, 1, 0); settle();
    // R6 clean line still clean: hit, no supply, moves to shared
    snoop(O_RD, 12'h132, 1, 1, 0, "R6 snoop read clean no supply");
    // R6 confirm now shared: write needs invalidate
    push_bus(O_INV, 12'h132, "R6 clean line downgraded to shared");
    push_done(S_D, "R5 upgrade done");
    req(12'h132, 1, 1); grant(); settle();
    // R8 noncoherent snoop ignored
    snoop(O_INV, 12'h132, 0, 0, 0, "R8 noncoherent snoop no response");
    push_done(S_D, "R8 line unchanged after nc snoop");
    req(12'h132, 0, 1); settle();

    // R9 pending read killed by invalidate
    push_bus(O_RD, 12'h045, "R9 read issued");
    push_done(S_I, "R9 killed fill invalid");
    req(12'h045, 0, 1); grant();
    snoop(O_INV, 12'h045, 1, 0, 0, "R9 snoop during pending");
    fill(0); settle();
    push_bus(O_RD, 12'h045, "R9 line stayed invalid");
    push_done(S_C, "R9 refill clean");
    req(12'h045, 0, 1); grant(); fill(0); settle();

    // R10 upgrade lost before grant -> read exclusive
    push_bus(O_RD, 12'h056, "R10 setup read");
    push_done(S_S, "R10 setup shared");
    req(12'h056, 0, 1); grant(); fill(1); settle();
    push_bus(O_RDX, 12'h056, "R10 upgrade becomes rdx");
    push_done(S_D, "R10 completes dirty");
    req(12'h056, 1, 1);
    snoop(O_INV, 12'h056, 1, 1, 0, "R10 snoop steals shared line");
    grant(); fill(0); settle();

    repeat (5) @(negedge clk);
    chk(exp_bus.size() == 0, "R12 all expected bus ops seen", exp_bus.size(), 0);
    chk(exp_done.size() == 0, "R2 all completions seen", exp_done.size(), 0);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule